// File: doc/BRIEF.md
# Watchdog Timer with Synchronized Refresh

This block is a watchdog for a system that software must service at regular intervals. Software reaches it through a small register bus on the bus clock. A timeout counter advances on a counter tick. That tick is either every bus cycle or each rising edge of a slow low-power oscillator of about 1 kHz, and in both cases it is then divided by a 3-bit prescaler. When the counter reaches the programmed 32-bit limit, the block raises a reset request that stays high until the block is reset.

Two keyed sequences guard the block. An unlock pair of writes opens the configuration registers for a limited window. A refresh pair of writes restarts the counter. A refresh is accepted in the bus domain and then has to cross into the counter domain, which takes two counter ticks. A refresh accepted while an earlier one is still crossing starts the crossing over. Software must therefore space its refreshes further apart than the crossing time, for example by polling the counter readback until it shows 0.

The unlock tracker has three states. `LK_LOCKED` moves to `LK_HALF` on the first key. `LK_HALF` moves to `LK_OPEN` on the second key, or back to `LK_LOCKED` with a fault. `LK_OPEN` returns to `LK_LOCKED` when the window ends, or moves to `LK_HALF` on a new first key. The refresh tracker has two states: `RF_IDLE` moves to `RF_ARMED` on the first refresh key, and `RF_ARMED` returns to `RF_IDLE` on any other refresh write. The second key accepts the refresh.

Top module: `wdt_top`

## Requirements
- R1: After reset, the reset request is low, the counter reads 0, the timeout reads 0x0000_0100, and the control register reads 0x0005. Control bits are: bit 0 enable, bit 1 source (1 = bus clock, 0 = slow oscillator), bit 2 allow-update, bit 3 wait-enable, bit 4 stop-enable. Register addresses are: 0 control, 1 timeout high, 2 timeout low, 3 prescaler (bits 2:0), 4 unlock, 5 refresh, 6 counter high, 7 counter low.
- R2: Writing 0xC520 and then 0xD928 to address 4, with the second write at most 20 bus cycles after the first, opens configuration writes for the 64 bus cycles that follow the second write.
- R3: Any of the following raises the reset request: a value at address 4 that is not the expected key, or a second unlock key that arrives more than 20 cycles after the first.
- R4: Writes to addresses 0 to 3 are ignored outside the open window, and also while allow-update (control bit 2) is 0. Readback shows the old value.
- R5: Writing 0xA602 and then 0xB480 to address 5 accepts a refresh. Any other pair is ignored and raises no reset request.
- R6: An accepted refresh clears the counter on the second counter tick after acceptance. From then on the counter reads back as 0.
- R7: A refresh accepted while an earlier one is still crossing restarts the crossing. Refreshes repeated faster than two counter ticks never clear the counter, and the timeout is reached.
- R8: With the block enabled, the counter advances by one on each counter tick. A source tick is every bus cycle when control bit 1 is 1. Otherwise it is each rising edge of the slow oscillator, acted on two bus cycles after it is sampled. Every (prescaler + 1)-th source tick is a counter tick.
- R9: The reset request rises when the next count would reach or pass the timeout value. It stays high until reset.
- R10: A read returns its data one cycle later. Reading address 7 returns the counter's low half and captures its high half at the same moment. Reading address 6 returns that captured high half.
- R11: While enable (control bit 0) is 0, the counter is held at 0 and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lpo_i | input | 1 | Slow low-power oscillator, sampled in the bus domain |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid one cycle after the read strobe |
| wdt_rst_req_o | output | 1 | Sticky reset request |

## Verification
Read data arrives one cycle after the read strobe. A bad unlock key or the final counter tick raises the reset request one cycle after the edge that caused it. A slow-oscillator rise produces a source tick two cycles after it is sampled. A refresh clears the counter on the second counter tick after its key is taken. The bench drives inputs on the falling clock edge and keeps a behavioural reference model that it steps on each rising edge. On each falling edge it compares the reset request and the read data against that model, so every result is sampled in the cycle in which it becomes due. Targeted checks then confirm the boundary cases against values worked out from the requirements: a second unlock key at exactly 20 cycles and at 21 cycles, and refreshes issued back to back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CTRL_W = 5;
    localparam int CB_EN    = 0;
    localparam int CB_SRC   = 1;
    localparam int CB_ALLOW = 2;

    localparam logic [2:0] A_CTRL    = 3'd0;
    localparam logic [2:0] A_TOUT_HI = 3'd1;
    localparam logic [2:0] A_TOUT_LO = 3'd2;
    localparam logic [2:0] A_PRESC   = 3'd3;
    localparam logic [2:0] A_UNLOCK  = 3'd4;
    localparam logic [2:0] A_REFRESH = 3'd5;
    localparam logic [2:0] A_CNT_HI  = 3'd6;
    localparam logic [2:0] A_CNT_LO  = 3'd7;

    localparam logic [15:0] UNL_KEY1 = 16'hC520;
    localparam logic [15:0] UNL_KEY2 = 16'hD928;
    localparam logic [15:0] REF_KEY1 = 16'hA602;
    localparam logic [15:0] REF_KEY2 = 16'hB480;

    typedef enum logic [1:0] {LK_LOCKED, LK_HALF, LK_OPEN} lk_state_e;
    typedef enum logic {RF_IDLE, RF_ARMED} rf_state_e;
endpackage

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm import wdt_pkg::*; #(
    parameter int UNL_GAP  = 20,
    parameter int OPEN_CYC = 64
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_i,
    input  logic [2:0]  addr_i,
    input  logic [15:0] wdata_i,
    output logic        cfg_open_o,
    output logic        ref_acc_o,
    output logic        fault_o
);
    localparam int GW = $clog2(UNL_GAP + 1);
    localparam int OW = $clog2(OPEN_CYC + 1);

    lk_state_e lk_q, lk_d;
    rf_state_e rf_q, rf_d;
    logic [GW-1:0] gap_q, gap_d;
    logic [OW-1:0] open_q, open_d;
    logic unl_wr, ref_wr, fault_w;

    assign unl_wr = wr_i && (addr_i == A_UNLOCK);
    assign ref_wr = wr_i && (addr_i == A_REFRESH);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lk_q   <= LK_LOCKED;
            rf_q   <= RF_IDLE;
            gap_q  <= '0;
            open_q <= '0;
        end else begin
            lk_q   <= lk_d;
            rf_q   <= rf_d;
            gap_q  <= gap_d;
            open_q <= open_d;
        end
    end

    always_comb begin
        lk_d    = lk_q;
        gap_d   = gap_q;
        open_d  = open_q;
        fault_w = 1'b0;
        unique case (lk_q)
            LK_LOCKED: begin
                if (unl_wr) begin
                    if (wdata_i == UNL_KEY1) begin
                        lk_d  = LK_HALF;
                        gap_d = GW'(1);
                    end else begin
                        fault_w = 1'b1;
                    end
                end
            end
            LK_HALF: begin
                if (unl_wr) begin
                    if (wdata_i == UNL_KEY2) begin
                        lk_d   = LK_OPEN;
                        open_d = OW'(1);
                    end else begin
                        lk_d    = LK_LOCKED;
                        fault_w = 1'b1;
                    end
                end else if (gap_q == GW'(UNL_GAP)) begin
                    lk_d    = LK_LOCKED;
                    fault_w = 1'b1;
                end else begin
                    gap_d = gap_q + GW'(1);
                end
            end
            LK_OPEN: begin
                if (unl_wr) begin
                    if (wdata_i == UNL_KEY1) begin
                        lk_d  = LK_HALF;
                        gap_d = GW'(1);
                    end else begin
                        lk_d    = LK_LOCKED;
                        fault_w = 1'b1;
                    end
                end else if (open_q == OW'(OPEN_CYC)) begin
                    lk_d = LK_LOCKED;
                end else begin
                    open_d = open_q + OW'(1);
                end
            end
            default: lk_d = LK_LOCKED;
        endcase

        rf_d = rf_q;
        if (ref_wr) begin
            rf_d = (wdata_i == REF_KEY1) ? RF_ARMED : RF_IDLE;
        end
    end

    always_comb begin
        cfg_open_o = (lk_q == LK_OPEN);
        ref_acc_o  = (rf_q == RF_ARMED) && ref_wr && (wdata_i == REF_KEY2);
        fault_o    = fault_w;
    end
endmodule

// File: rtl/wdt_tick_src.sv
module wdt_tick_src #(
    parameter int PRE_W    = 3,
    parameter int LPO_SYNC = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lpo_i,
    input  logic             src_bus_i,
    input  logic [PRE_W-1:0] presc_i,
    output logic             tick_o
);
    logic [LPO_SYNC:0] sh_q;
    logic [PRE_W-1:0]  pc_q;
    logic              rise_w, src_w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[LPO_SYNC-1:0], lpo_i};
    end

    assign rise_w = sh_q[LPO_SYNC-1] & ~sh_q[LPO_SYNC];
    assign src_w  = src_bus_i | rise_w;
    assign tick_o = src_w && (pc_q >= presc_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    pc_q <= '0;
        else if (src_w) pc_q <= tick_o ? '0 : pc_q + PRE_W'(1);
    end
endmodule

// File: rtl/wdt_cnt_dom.sv
module wdt_cnt_dom #(
    parameter int CNT_W  = 32,
    parameter int SYNC_N = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             halt_i,
    input  logic [CNT_W-1:0] tout_i,
    input  logic             ref_acc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pend_o,
    output logic             expired_o
);
    localparam int SW = $clog2(SYNC_N + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [SW-1:0]    stage_q;
    logic             pend_q, land_w;

    assign land_w = pend_q && tick_i && (stage_q == SW'(SYNC_N - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q  <= 1'b0;
            stage_q <= '0;
        end else if (ref_acc_i) begin
            pend_q  <= 1'b1;
            stage_q <= '0;
        end else if (pend_q && tick_i) begin
            if (land_w) pend_q  <= 1'b0;
            else        stage_q <= stage_q + SW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                cnt_q <= '0;
        else if (!en_i)             cnt_q <= '0;
        else if (land_w)            cnt_q <= '0;
        else if (tick_i && !halt_i) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign expired_o = en_i && tick_i && !land_w && !halt_i &&
                       (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, tout_i});
    assign cnt_o  = cnt_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/wdt_top.sv
module wdt_top import wdt_pkg::*; #(
    parameter int          CNT_W    = 32,
    parameter logic [31:0] TOUT_RST = 32'h0000_0100,
    parameter int          PRE_W    = 3,
    parameter int          UNL_GAP  = 20,
    parameter int          OPEN_CYC = 64,
    parameter int          SYNC_N   = 2,
    parameter int          LPO_SYNC = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        lpo_i,
    input  logic        bus_wr_i,
    input  logic        bus_rd_i,
    input  logic [2:0]  bus_addr_i,
    input  logic [15:0] bus_wdata_i,
    output logic [15:0] bus_rdata_o,
    output logic        wdt_rst_req_o
);
    localparam int HI_W = CNT_W - 16;

    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  tout_q, cnt_w;
    logic [PRE_W-1:0]  presc_q;
    logic [15:0]       rdata_q;
    logic [HI_W-1:0]   hold_q;
    logic req_q, cfg_open, ref_acc, key_fault, tick, expired, pend_w, cfg_we;

    wdt_key_fsm #(.UNL_GAP(UNL_GAP), .OPEN_CYC(OPEN_CYC)) u_keys (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .cfg_open_o(cfg_open), .ref_acc_o(ref_acc),
        .fault_o(key_fault));

    wdt_tick_src #(.PRE_W(PRE_W), .LPO_SYNC(LPO_SYNC)) u_tick (
        .clk_i(clk_i), .rst_ni(rst_ni), .lpo_i(lpo_i),
        .src_bus_i(ctrl_q[CB_SRC]), .presc_i(presc_q), .tick_o(tick));

    wdt_cnt_dom #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .en_i(ctrl_q[CB_EN]),
        .halt_i(req_q), .tout_i(tout_q), .ref_acc_i(ref_acc), .cnt_o(cnt_w),
        .pend_o(pend_w), .expired_o(expired));

    assign cfg_we = bus_wr_i && cfg_open && ctrl_q[CB_ALLOW] && (bus_addr_i <= A_PRESC);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q  <= CTRL_W'(5);
            tout_q  <= CNT_W'(TOUT_RST);
            presc_q <= '0;
            rdata_q <= '0;
            hold_q  <= '0;
            req_q   <= 1'b0;
        end else begin
            if (cfg_we) begin
                case (bus_addr_i)
                    A_CTRL:    ctrl_q              <= bus_wdata_i[CTRL_W-1:0];
                    A_TOUT_HI: tout_q[CNT_W-1:16]  <= bus_wdata_i[HI_W-1:0];
                    A_TOUT_LO: tout_q[15:0]        <= bus_wdata_i;
                    A_PRESC:   presc_q             <= bus_wdata_i[PRE_W-1:0];
                    default: ;
                endcase
            end
            if (bus_rd_i) begin
                case (bus_addr_i)
                    A_CTRL:    rdata_q <= {{(16-CTRL_W){1'b0}}, ctrl_q};
                    A_TOUT_HI: rdata_q <= 16'(tout_q[CNT_W-1:16]);
                    A_TOUT_LO: rdata_q <= tout_q[15:0];
                    A_PRESC:   rdata_q <= {{(16-PRE_W){1'b0}}, presc_q};
                    A_CNT_HI:  rdata_q <= 16'(hold_q);
                    A_CNT_LO: begin
                        rdata_q <= cnt_w[15:0];
                        hold_q  <= cnt_w[CNT_W-1:16];
                    end
                    default:   rdata_q <= '0;
                endcase
            end
            req_q <= req_q | key_fault | expired;
        end
    end

    assign bus_rdata_o   = rdata_q;
    assign wdt_rst_req_o = req_q;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_i,
    input logic [2:0]       addr_i,
    input logic [15:0]      wdata_i,
    input logic             req_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             pend_i,
    input logic             en_i,
    input logic             open_i,
    input logic [CNT_W-1:0] tout_i
);
    a_r9_req_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> req_i);

    a_r3_bad_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == 3'd4 && wdata_i != 16'hC520 && wdata_i != 16'hD928) |=> req_i);

    a_r6_land_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pend_i) |-> (cnt_i == '0));

    a_r11_disabled_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (cnt_i == '0));

    a_r4_cfg_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(tout_i) |-> $past(open_i));

    a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_i != $past(cnt_i)) |-> (cnt_i == $past(cnt_i) + CNT_W'(1) || cnt_i == '0));
endmodule

bind wdt_top wdt_chk #(.CNT_W(32)) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .req_i(wdt_rst_req_o), .cnt_i(cnt_w), .pend_i(pend_w),
    .en_i(ctrl_q[0]), .open_i(cfg_open), .tout_i(tout_q));

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
    logic clk = 1'b0, rst_n = 1'b0, lpo = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wd = 16'd0;
    wire  [15:0] rdata;
    wire         req;

    always #2 clk = ~clk;

    wdt_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .lpo_i(lpo), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wd), .bus_rdata_o(rdata), .wdt_rst_req_o(req));

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;
    string tag = "R1";

    // slow oscillator: 16 bus cycles per period
    always @(negedge clk) begin
        cyc++;
        lpo = ((cyc / 8) % 2) == 1;
    end

    // behavioural reference model
    logic [2:0]  m_l;
    int          m_pc, m_presc, m_lk, m_gap, m_open, m_rf, m_stage;
    logic [4:0]  m_ctrl;
    logic [31:0] m_tout, m_cnt;
    logic [15:0] m_rdata, m_hold;
    bit          m_pend, m_req;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_l = 0; m_pc = 0; m_presc = 0; m_lk = 0; m_gap = 0; m_open = 0; m_rf = 0;
            m_stage = 0; m_ctrl = 5'h05; m_tout = 32'h100; m_cnt = 0; m_rdata = 0;
            m_hold = 0; m_pend = 0; m_req = 0;
        end else begin
            bit src, tk, land, racc, fault, expd, uw, cfg;
            int n_lk, n_gap, n_open;
            src   = m_ctrl[1] || (m_l[1] && !m_l[2]);
            tk    = src && (m_pc >= m_presc);
            land  = m_pend && tk && (m_stage == 1);
            racc  = (m_rf == 1) && wr && addr == 3'd5 && wd == 16'hB480;
            expd  = m_ctrl[0] && tk && !land && !m_req && ({1'b0, m_cnt} + 33'd1 >= {1'b0, m_tout});
            uw    = wr && addr == 3'd4;
            cfg   = wr && (m_lk == 2) && m_ctrl[2] && addr <= 3'd3;
            fault = 0; n_lk = m_lk; n_gap = m_gap; n_open = m_open;
            if (m_lk == 0) begin
                if (uw) begin
                    if (wd == 16'hC520) begin n_lk = 1; n_gap = 1; end else fault = 1;
                end
            end else if (m_lk == 1) begin
                if (uw) begin
                    if (wd == 16'hD928) begin n_lk = 2; n_open = 1; end
                    else begin n_lk = 0; fault = 1; end
                end else if (m_gap == 20) begin n_lk = 0; fault = 1; end
                else n_gap = m_gap + 1;
            end else begin
                if (uw) begin
                    if (wd == 16'hC520) begin n_lk = 1; n_gap = 1; end
                    else begin n_lk = 0; fault = 1; end
                end else if (m_open == 64) n_lk = 0;
                else n_open = m_open + 1;
            end
            if (rd) begin
                case (addr)
                    3'd0: m_rdata = {11'd0, m_ctrl};
                    3'd1: m_rdata = m_tout[31:16];
                    3'd2: m_rdata = m_tout[15:0];
                    3'd3: m_rdata = 16'(m_presc);
                    3'd6: m_rdata = m_hold;
                    3'd7: begin m_rdata = m_cnt[15:0]; m_hold = m_cnt[31:16]; end
                    default: m_rdata = 0;
                endcase
            end
            if (racc) begin m_pend = 1; m_stage = 0; end
            else if (m_pend && tk) begin
                if (land) m_pend = 0; else m_stage = m_stage + 1;
            end
            if (!m_ctrl[0]) m_cnt = 0;
            else if (land) m_cnt = 0;
            else if (tk && !m_req) m_cnt = m_cnt + 1;
            if (src) m_pc = tk ? 0 : m_pc + 1;
            m_l = {m_l[1:0], lpo};
            if (wr && addr == 3'd5) m_rf = (wd == 16'hA602) ? 1 : 0;
            m_lk = n_lk; m_gap = n_gap; m_open = n_open;
            m_req = m_req | fault | expd;
            if (cfg) begin
                case (addr)
                    3'd0: m_ctrl = wd[4:0];
                    3'd1: m_tout[31:16] = wd;
                    3'd2: m_tout[15:0] = wd;
                    default: m_presc = int'(wd[2:0]);
                endcase
            end
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (req !== m_req || rdata !== m_rdata) begin
                errors++;
                $display("FAIL %s: req=%0b rdata=%h expected req=%0b rdata=%h",
                         tag, req, rdata, m_req, m_rdata);
            end
        end
    end

    task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", t, got, exp);
        end
    endtask

    task automatic put(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1; rd = 0; addr = a; wd = d;
    endtask

    task automatic quiet(input int n);
        repeat (n) begin @(negedge clk); wr = 0; rd = 0; end
    endtask

    task automatic get(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk); wr = 0; rd = 1; addr = a;
        @(negedge clk); rd = 0; v = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); wr = 0; rd = 0; rst_n = 0;
        quiet(3);
        rst_n = 1;
    endtask

    task automatic unlock();
        put(3'd4, 16'hC520); put(3'd4, 16'hD928); quiet(1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v, v2;
        // R1 reset state
        do_reset(); tag = "R1";
        chk("R1 req", {31'd0, req}, 0);
        get(3'd0, v); chk("R1 ctrl", {16'd0, v}, 32'h5);
        get(3'd2, v); chk("R1 tout lo", {16'd0, v}, 32'h100);
        get(3'd7, v); chk("R1 cnt lo", {16'd0, v}, 0);

        // R4 locked write ignored; R2 unlock and configure
        tag = "R4"; put(3'd2, 16'h1234); quiet(1);
        get(3'd2, v); chk("R4 locked write", {16'd0, v}, 32'h100);
        tag = "R2"; unlock();
        put(3'd2, 16'h0400); put(3'd3, 16'h0001); put(3'd0, 16'h0007); quiet(1);
        get(3'd2, v); chk("R2 tout lo", {16'd0, v}, 32'h400);
        get(3'd3, v); chk("R2 presc", {16'd0, v}, 32'h1);
        tag = "R4"; quiet(70); put(3'd2, 16'h9999); quiet(1);
        get(3'd2, v); chk("R4 after window", {16'd0, v}, 32'h400);

        // R8 / R10 counting and split readback
        tag = "R8"; quiet(20);
        get(3'd7, v); get(3'd7, v2); chk("R8 advance over two reads", {16'd0, v2 - v}, 32'h1);
        tag = "R10"; get(3'd6, v); chk("R10 captured hi", {16'd0, v}, 0);

        // R5 ignored pair, then R6 accepted refresh
        tag = "R5"; put(3'd5, 16'hA602); put(3'd5, 16'h1234); quiet(10);
        get(3'd7, v); chk("R5 bad pair no clear", {31'd0, v > 16'd6}, 1);
        chk("R5 no reset", {31'd0, req}, 0);
        tag = "R6"; put(3'd5, 16'hA602); put(3'd5, 16'hB480); quiet(8);
        get(3'd7, v); chk("R6 cleared", {31'd0, v <= 16'd6}, 1);

        // R7 refresh every two cycles never lands
        tag = "R7";
        for (int i = 0; i < 1200; i++) begin put(3'd5, 16'hA602); put(3'd5, 16'hB480); end
        quiet(2); chk("R7 expired", {31'd0, req}, 1);

        // R9 timeout and stickiness
        do_reset(); tag = "R9"; unlock();
        put(3'd2, 16'h0020); put(3'd0, 16'h0007); quiet(10);
        chk("R9 before limit", {31'd0, req}, 0);
        quiet(40); chk("R9 fired", {31'd0, req}, 1);
        quiet(30); chk("R9 sticky", {31'd0, req}, 1);

        // R3 bad key, boundary and late second key
        do_reset(); tag = "R3"; put(3'd4, 16'h1111); quiet(2);
        chk("R3 bad key", {31'd0, req}, 1);
        do_reset(); put(3'd4, 16'hC520); quiet(19); put(3'd4, 16'hD928);
        put(3'd3, 16'h0002); quiet(2);
        chk("R3 gap 20 ok", {31'd0, req}, 0);
        get(3'd3, v); chk("R2 gap 20 opens", {16'd0, v}, 32'h2);
        do_reset(); put(3'd4, 16'hC520); quiet(20); put(3'd4, 16'hD928); quiet(2);
        chk("R3 gap 21 late", {31'd0, req}, 1);

        // R4 allow-update cleared
        do_reset(); tag = "R4"; unlock();
        put(3'd0, 16'h0003); put(3'd2, 16'h0077); quiet(1);
        get(3'd2, v); chk("R4 allow clear", {16'd0, v}, 32'h100);
        get(3'd0, v); chk("R4 ctrl kept", {16'd0, v}, 32'h3);

        // R11 disabled counter
        do_reset(); tag = "R11"; unlock(); put(3'd0, 16'h0006); quiet(300);
        get(3'd7, v); chk("R11 held", {16'd0, v}, 0);
        chk("R11 no reset", {31'd0, req}, 0);

        // R8 slow source with refresh landing (R6) and timeout (R9)
        do_reset(); tag = "R8"; unlock(); put(3'd2, 16'h0008); quiet(40);
        put(3'd5, 16'hA602); quiet(3); put(3'd5, 16'hB480); quiet(60);
        chk("R8 slow not yet", {31'd0, req}, 0);
        quiet(200); chk("R8 slow expired", {31'd0, req}, 1);

        summary();
        $finish;
    end
endmodule